// File: doc/BRIEF.md
# Fractional-Address Interpolating Delay Reader

This block is a per-sample varispeed and pitch-shift reader for an audio circular delay buffer. Each accepted sample strobe does four things. It writes the new input sample into the buffer, mixed with a scaled copy of the buffer's oldest word so the buffer loops with feedback. It advances a fixed-point read phase by a step taken from the speed control. It fetches the two stored words on either side of the fractional read position. It then presents their linear interpolation on the output with a one-cycle valid pulse.

The read phase has an integer part of `ADDR_W` bits and a fraction of `FRAC_W` bits. It is an absolute buffer position that wraps modulo the buffer length. The write pointer advances by one word per strobe, so a step of one word (256 with the default fraction width) replays the input at its original speed. A smaller step lowers the pitch and a larger step raises it. The buffer is a simple synchronous RAM with one write port and one registered read port. The three reads that each sample needs are made one after another. After reset the whole buffer is cleared by a sweep of one word per clock.

Top module: `frac_delay_reader`

## Requirements
- R1: After reset is released, the block spends exactly 2^ADDR_W clocks writing zero to every buffer word. During that time strobes are ignored and `out_valid_o` stays low. While in reset and after it, `out_o` is 0 and `out_valid_o` is 0 until the first result. The read phase and the write pointer both restart at 0.
- R2: A strobe is accepted when the block is idle, meaning it is not clearing and has no sample in flight. `out_valid_o` is then a single-clock pulse that rises on the 4th rising edge counted from the edge that samples the strobe. A strobe that arrives while a sample is in flight is ignored.
- R3: On each accepted strobe the phase grows by step = floor(speed × 2^(FRAC_W+1) / 2^CTRL_W), which is 0 to just under 2 words. The new phase is taken modulo 2^(ADDR_W+FRAC_W), and this updated phase is the one used for that strobe's reads. Without a strobe the phase holds.
- R4: The lower word is read at the phase's integer part (phase >> FRAC_W). The upper word is read at that integer plus one.
- R5: out = lower + floor((upper − lower) × frac / 2^FRAC_W), where frac is the low FRAC_W bits of the phase. The output therefore always lies between the two words it was formed from.
- R6: When the integer part is 2^ADDR_W − 1, the upper word is taken from address 0.
- R7: All three reads made for a strobe see the buffer contents from before that strobe's own write.
- R8: The write pointer starts at 0 and advances by one per accepted strobe. It stores sat(x + floor(tap × gain / 2^CTRL_W)), where tap is the word at write pointer + 1 modulo 2^ADDR_W. That word is the one written 2^ADDR_W − 1 strobes earlier, which makes it the oldest word.
- R9: Sums on sample data are two's complement and saturate to [−2^(DATA_W−1), 2^(DATA_W−1) − 1] instead of wrapping.
- R10: The sample, speed and gain are sampled on the clock edge that accepts the strobe. Later changes before the next accepted strobe have no effect on that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| smp_stb_i | input | 1 | Sample strobe, one clock wide |
| smp_i | input | DATA_W | Signed input sample |
| speed_i | input | CTRL_W | Unsigned speed fraction, scales a base step of 2 words |
| fb_gain_i | input | CTRL_W | Unsigned feedback gain fraction |
| out_o | output | DATA_W | Signed interpolated output sample |
| out_valid_o | output | 1 | One-clock pulse marking a new `out_o` |

## Verification
The assertions check the following on every clock. The valid pulse lasts one clock and always follows an accepted strobe by exactly four edges. No result appears while the buffer is clearing. Each phase update adds exactly the step derived from the sampled speed, and the phase holds otherwise. Every output lies between the two words it was blended from. Only the bench's scenarios can show the rest against an independent model of buffer, phase and feedback. That covers the exact interpolated values, the wrap of the upper read to address 0, and reads that see the buffer as it stood before the current write. It also covers the feedback tap taken from the oldest word, saturation under full-scale feedback, strobes ignored while busy or clearing, and a cleared buffer after a mid-run reset.

// File: rtl/frac_delay_pkg.sv
// Package: shared types for the fractional delay reader.
// Assumes: nothing beyond IEEE 1800-2017.
package frac_delay_pkg;

    // Sequencer states. The reads of a sample are serialised on one read port.
    typedef enum logic [2:0] {
        ST_CLEAR   = 3'd0,  // post-reset sweep writing zero
        ST_IDLE    = 3'd1,  // waiting for a strobe, tap read pending
        ST_GET_TAP = 3'd2,  // tap word on read data, lower read issued
        ST_GET_LO  = 3'd3,  // lower word on read data, upper read issued, write done
        ST_GET_HI  = 3'd4   // upper word on read data, result formed
    } seq_state_e;

endpackage

// File: rtl/frac_phase_acc.sv
// Module: frac_phase_acc
// Fixed-point read phase accumulator. On adv_i it adds a step derived from
// the speed fraction (base step of two words) and wraps modulo the phase width.
// Assumes: speed_i is held valid in the cycle adv_i is high.
module frac_phase_acc #(
    parameter int ADDR_W = 10,
    parameter int FRAC_W = 8,
    parameter int CTRL_W = 10
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       adv_i,
    input  logic [CTRL_W-1:0]          speed_i,
    output logic [ADDR_W+FRAC_W-1:0]   phase_o
);
    localparam int ACC_W  = ADDR_W + FRAC_W;
    localparam int STEP_W = FRAC_W + 1;
    localparam int SCL_W  = CTRL_W + FRAC_W + 1;

    logic [SCL_W-1:0]  scaled;
    logic [STEP_W-1:0] step;
    logic [ACC_W-1:0]  phase_q;

    // Scale speed by the two-word base and drop the control fraction bits.
    always_comb begin
        scaled = {speed_i, {(FRAC_W+1){1'b0}}};
        step   = scaled[SCL_W-1:CTRL_W];
    end

    // Advance and wrap the phase on each accepted strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (adv_i) begin
            phase_q <= phase_q + {{(ACC_W-STEP_W){1'b0}}, step};
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/frac_dly_ram.sv
// Module: frac_dly_ram
// Simple dual-port synchronous RAM: one write port, one registered read port.
// A read and write to the same word in one cycle returns the old contents.
// Assumes: contents are initialised by the owner (no reset on the array).
module frac_dly_ram #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Registered read with read-before-write, plus the write port.
    always_ff @(posedge clk_i) begin
        rdata_o <= mem[raddr_i];
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end
endmodule

// File: rtl/frac_fb_mix.sv
// Module: frac_fb_mix
// Combinational write-path mixer: input sample plus tap scaled by an unsigned
// gain fraction (floor), saturated to the sample width.
// Assumes: two's-complement samples, gain in units of 2^-CTRL_W.
module frac_fb_mix #(
    parameter int DATA_W = 24,
    parameter int CTRL_W = 10
) (
    input  logic signed [DATA_W-1:0] smp_i,
    input  logic signed [DATA_W-1:0] tap_i,
    input  logic        [CTRL_W-1:0] gain_i,
    output logic signed [DATA_W-1:0] mix_o
);
    localparam int MW = DATA_W + CTRL_W + 2;
    localparam logic signed [MW-1:0] MAXV = {{(MW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [MW-1:0] MINV = {{(MW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [MW-1:0] tap_x, gain_x, prod, part, sum;

    // Scale the tap, add the sample and clamp to the sample range.
    always_comb begin
        tap_x  = MW'(tap_i);
        gain_x = MW'({1'b0, gain_i});
        prod   = tap_x * gain_x;
        part   = prod >>> CTRL_W;
        sum    = MW'(smp_i) + part;
        if (sum > MAXV) begin
            mix_o = MAXV[DATA_W-1:0];
        end else if (sum < MINV) begin
            mix_o = MINV[DATA_W-1:0];
        end else begin
            mix_o = sum[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/frac_lerp.sv
// Module: frac_lerp
// Combinational linear interpolator: lo + floor((hi - lo) * frac / 2^FRAC_W),
// saturated to the sample width.
// Assumes: frac is an unsigned fraction of FRAC_W bits.
module frac_lerp #(
    parameter int DATA_W = 24,
    parameter int FRAC_W = 8
) (
    input  logic signed [DATA_W-1:0] lo_i,
    input  logic signed [DATA_W-1:0] hi_i,
    input  logic        [FRAC_W-1:0] frac_i,
    output logic signed [DATA_W-1:0] y_o
);
    localparam int PW = DATA_W + FRAC_W + 2;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [PW-1:0] lo_x, diff, frac_x, prod, sum;

    // Blend the two words by the fraction and clamp to the sample range.
    always_comb begin
        lo_x   = PW'(lo_i);
        diff   = PW'(hi_i) - lo_x;
        frac_x = PW'({1'b0, frac_i});
        prod   = diff * frac_x;
        sum    = lo_x + (prod >>> FRAC_W);
        if (sum > MAXV) begin
            y_o = MAXV[DATA_W-1:0];
        end else if (sum < MINV) begin
            y_o = MINV[DATA_W-1:0];
        end else begin
            y_o = sum[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/frac_delay_reader.sv
// Module: frac_delay_reader (top)
// Per-sample varispeed reader over a circular delay buffer with feedback.
// Sequence per accepted strobe: tap read, lower read, upper read (one read
// port), buffer write in the lower-read cycle, result four edges after accept.
// Assumes: strobes are at least four clocks apart, or extra ones are dropped.
module frac_delay_reader #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 10,
    parameter int FRAC_W = 8,
    parameter int CTRL_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              smp_stb_i,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [CTRL_W-1:0] speed_i,
    input  logic [CTRL_W-1:0] fb_gain_i,
    output logic [DATA_W-1:0] out_o,
    output logic              out_valid_o
);
    import frac_delay_pkg::*;

    localparam int ACC_W = ADDR_W + FRAC_W;
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    seq_state_e        state_q;
    logic [ADDR_W-1:0] clr_cnt_q;
    logic [ADDR_W-1:0] wr_ptr_q;
    logic [DATA_W-1:0] smp_q;
    logic [CTRL_W-1:0] gain_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] out_q;
    logic              valid_q;

    logic              adv;
    logic [ACC_W-1:0]  phase;
    logic [ADDR_W-1:0] rd_int;
    logic [FRAC_W-1:0] rd_frac;
    logic [ADDR_W-1:0] ram_raddr;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] mix;
    logic [DATA_W-1:0] lerp_y;

    assign adv     = smp_stb_i && (state_q == ST_IDLE);
    assign rd_int  = phase[ACC_W-1:FRAC_W];
    assign rd_frac = phase[FRAC_W-1:0];

    frac_phase_acc #(
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W),
        .CTRL_W (CTRL_W)
    ) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .adv_i   (adv),
        .speed_i (speed_i),
        .phase_o (phase)
    );

    // Read address per state: tap while idle, then lower, then upper word.
    always_comb begin
        case (state_q)
            ST_GET_TAP: ram_raddr = rd_int;
            ST_GET_LO:  ram_raddr = rd_int + ADDR_W'(1);
            default:    ram_raddr = wr_ptr_q + ADDR_W'(1);
        endcase
    end

    // Write port: zero sweep after reset, sample write in the lower-read cycle.
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = wr_ptr_q;
        ram_wdata = wdata_q;
        if (state_q == ST_CLEAR) begin
            ram_we    = 1'b1;
            ram_waddr = clr_cnt_q;
            ram_wdata = '0;
        end else if (state_q == ST_GET_LO) begin
            ram_we    = 1'b1;
        end
    end

    frac_dly_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk_i   (clk_i),
        .we_i    (ram_we),
        .waddr_i (ram_waddr),
        .wdata_i (ram_wdata),
        .raddr_i (ram_raddr),
        .rdata_o (ram_rdata)
    );

    frac_fb_mix #(
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) u_mix (
        .smp_i  (smp_q),
        .tap_i  (ram_rdata),
        .gain_i (gain_q),
        .mix_o  (mix)
    );

    frac_lerp #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W)
    ) u_lerp (
        .lo_i   (lo_q),
        .hi_i   (ram_rdata),
        .frac_i (rd_frac),
        .y_o    (lerp_y)
    );

    // Sequencer: clear sweep, accept, three serial reads, result.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q   <= ST_CLEAR;
            clr_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_CLEAR: begin
                    clr_cnt_q <= clr_cnt_q + ADDR_W'(1);
                    if (clr_cnt_q == LAST_ADDR) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_IDLE:    if (adv) state_q <= ST_GET_TAP;
                ST_GET_TAP: state_q <= ST_GET_LO;
                ST_GET_LO:  state_q <= ST_GET_HI;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Datapath registers: capture inputs, mixed write word, lower word, result.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            smp_q    <= '0;
            gain_q   <= '0;
            lo_q     <= '0;
            wdata_q  <= '0;
            out_q    <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (adv) begin
                smp_q  <= smp_i;
                gain_q <= fb_gain_i;
            end
            if (state_q == ST_GET_TAP) begin
                wdata_q <= mix;
            end
            if (state_q == ST_GET_LO) begin
                lo_q <= ram_rdata;
            end
            if (state_q == ST_GET_HI) begin
                out_q    <= lerp_y;
                valid_q  <= 1'b1;
                wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
            end
        end
    end

    assign out_o       = out_q;
    assign out_valid_o = valid_q;
endmodule

// File: rtl/frac_delay_reader_chk.sv
// Module: frac_delay_reader_chk
// Property checker for frac_delay_reader, attached by the bind below.
// Assumes: connected to the top's ports and a few internal nets.
module frac_delay_reader_chk #(
    parameter int DATA_W = 24,
    parameter int ADDR_W = 10,
    parameter int FRAC_W = 8,
    parameter int CTRL_W = 10
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [CTRL_W-1:0]        speed_i,
    input  logic signed [DATA_W-1:0] out_o,
    input  logic                     out_valid_o,
    input  logic                     clearing_i,
    input  logic                     adv_i,
    input  logic [ADDR_W+FRAC_W-1:0] phase_i,
    input  logic signed [DATA_W-1:0] lo_i,
    input  logic signed [DATA_W-1:0] hi_i
);
    localparam int ACC_W = ADDR_W + FRAC_W;
    localparam int SCL_W = CTRL_W + FRAC_W + 1;

    logic [SCL_W-1:0] scl_c;
    logic [ACC_W-1:0] step_c;

    // Expected step from the speed input.
    always_comb begin
        scl_c  = {speed_i, {(FRAC_W+1){1'b0}}} >> CTRL_W;
        step_c = ACC_W'(scl_c);
    end

    // R2: the valid flag is a single-clock pulse
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |=> !out_valid_o);

    // R2: every result follows an accepted strobe by four edges
    a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> $past(adv_i, 4));

    // R1: no result while the buffer is being cleared
    a_r1_quiet_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clearing_i |-> !out_valid_o);

    // R3: an accepted strobe adds exactly the derived step, modulo the phase width
    a_r3_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> phase_i == ACC_W'($past(phase_i) + $past(step_c)));

    // R3: the phase holds between strobes
    a_r3_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(phase_i));

    // R5: the result lies between the two words it was blended from
    a_r5_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> ((out_o >= $past(lo_i) && out_o <= $past(hi_i)) ||
                         (out_o <= $past(lo_i) && out_o >= $past(hi_i))));
endmodule

bind frac_delay_reader frac_delay_reader_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .FRAC_W (FRAC_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_i     (speed_i),
    .out_o       (out_o),
    .out_valid_o (out_valid_o),
    .clearing_i  (state_q == frac_delay_pkg::ST_CLEAR),
    .adv_i       (adv),
    .phase_i     (phase),
    .lo_i        (lo_q),
    .hi_i        (ram_rdata)
);

// File: tb/frac_delay_reader_bench.sv
// Bench for frac_delay_reader: table of stimulus vectors walked by one loop,
// expected results from an independent model of buffer, phase and feedback,
// followed by directed tests for reset, busy strobes, wrap and saturation.
module frac_delay_reader_bench;
    localparam int DATA_W = 24;
    localparam int ADDR_W = 10;
    localparam int FRAC_W = 8;
    localparam int CTRL_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int ACC_MASK = (1 << (ADDR_W + FRAC_W)) - 1;
    localparam longint SMAX = (64'sd1 <<< (DATA_W - 1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (DATA_W - 1));

    typedef struct packed {
        logic [DATA_W-1:0] smp;
        logic [CTRL_W-1:0] spd;
        logic [CTRL_W-1:0] gain;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{24'h001000, 10'd512,  10'd0},
        '{24'h7FF000, 10'd512,  10'd0},
        '{24'h800100, 10'd0,    10'd0},
        '{24'h123456, 10'd1023, 10'd512},
        '{24'hFEDCBA, 10'd256,  10'd1023},
        '{24'h000001, 10'd700,  10'd100},
        '{24'h3FFFFF, 10'd1,    10'd900},
        '{24'hC00000, 10'd511,  10'd0},
        '{24'h055555, 10'd513,  10'd333},
        '{24'hAAAAAA, 10'd768,  10'd1000},
        '{24'h000000, 10'd0,    10'd1023},
        '{24'h7FFFFF, 10'd1023, 10'd1023},
        '{24'h800000, 10'd128,  10'd1023},
        '{24'h010203, 10'd640,  10'd64},
        '{24'hF0F0F0, 10'd300,  10'd512},
        '{24'h0ABCDE, 10'd999,  10'd7}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              stb = 1'b0;
    logic [DATA_W-1:0] smp = '0;
    logic [CTRL_W-1:0] spd = '0;
    logic [CTRL_W-1:0] gain = '0;
    logic [DATA_W-1:0] out;
    logic              out_valid;

    int n_chk = 0;
    int n_fail = 0;
    int r6_hits = 0;
    int r9_hits = 0;

    // Reference model state
    longint mdl_mem [DEPTH];
    int     mdl_wp;
    int     mdl_acc;

    frac_delay_reader #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W),
        .CTRL_W (CTRL_W)
    ) u_frac_delay_reader (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .smp_stb_i   (stb),
        .smp_i       (smp),
        .speed_i     (spd),
        .fb_gain_i   (gain),
        .out_o       (out),
        .out_valid_o (out_valid)
    );

    always #4 clk = ~clk;  // 125 MHz

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) mdl_mem[i] = 0;
        mdl_wp  = 0;
        mdl_acc = 0;
    endtask

    // One strobe: compute expected value from the model, drive, check latency and value.
    task automatic strobe(input logic [DATA_W-1:0] s, input logic [CTRL_W-1:0] sp,
                          input logic [CTRL_W-1:0] g, input bit poke_busy);
        int     ip, fr, nv;
        longint lo, hi, tap, y, raw, w;
        string  tag;
        // R3: phase advance before the reads, wrap by masking
        mdl_acc = (mdl_acc + ((int'(sp) << (FRAC_W + 1)) >> CTRL_W)) & ACC_MASK;
        ip = mdl_acc >> FRAC_W;
        fr = mdl_acc & ((1 << FRAC_W) - 1);
        // R4, R6, R7: reads of the buffer before this strobe's write
        lo  = mdl_mem[ip];
        hi  = mdl_mem[(ip + 1) % DEPTH];
        tap = mdl_mem[(mdl_wp + 1) % DEPTH];
        // R5: linear interpolation with floor
        y = sat(lo + (((hi - lo) * fr) >>> FRAC_W));
        // R8, R9: feedback write with saturation
        raw = longint'($signed(s)) + ((tap * longint'(g)) >>> CTRL_W);
        w   = sat(raw);
        mdl_mem[mdl_wp] = w;
        mdl_wp = (mdl_wp + 1) % DEPTH;
        tag = "R5";
        if (ip == DEPTH - 1 && fr != 0) begin
            tag = "R6";
            r6_hits++;
        end
        if (raw != w) begin
            tag = "R9";
            r9_hits++;
        end

        @(negedge clk);
        stb = 1'b1; smp = s; spd = sp; gain = g;
        @(negedge clk);
        stb = poke_busy;  // R2: a strobe while busy must be dropped
        // R10: inputs change after acceptance and must not alter this result
        smp = ~s; spd = ~sp; gain = ~g;
        nv = 0;
        for (int n = 2; n <= 5; n++) begin
            @(negedge clk);
            stb = 1'b0;
            if (n == 4) begin
                if (!out_valid) nv = 99;
                chk({tag, " out (R3 R4 R7 R8 R10 model)"}, longint'($signed(out)), y);
            end else if (out_valid) begin
                nv++;
            end
        end
        chk("R2 valid timing", nv, 0);
    endtask

    initial begin
        model_reset();
        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1 out_valid in reset", out_valid, 0);
        chk("R1 out in reset", out, 0);
        rst_n = 1'b1;
        // R1: strobe during the clear sweep is ignored
        repeat (10) @(negedge clk);
        stb = 1'b1; smp = 24'h222222; spd = 10'd900; gain = 10'd500;
        @(negedge clk);
        stb = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            chk("R1 strobe during clear", seen, 0);
        end
        repeat (DEPTH) @(negedge clk);

        // Table walk
        for (int i = 0; i < 16; i++) strobe(VECS[i].smp, VECS[i].spd, VECS[i].gain, 1'b0);

        // R2: strobes while busy
        for (int i = 0; i < 3; i++) strobe(24'h100000 + 24'(i), 10'd400, 10'd200, 1'b1);

        // Long varied run: phase wraps, upper read wraps to word 0 (R6)
        for (int i = 0; i < 1200; i++)
            strobe(24'((i * 40503 + 12345) & 24'hFFFFFF), 10'((i * 37) % 1024),
                   10'((i * 13) % 1024), 1'b0);

        // Full-scale feedback loops drive saturation (R9)
        for (int i = 0; i < 1100; i++) strobe(24'h7FFFF0, 10'd512, 10'd1023, 1'b0);
        for (int i = 0; i < 1100; i++) strobe(24'h800010, 10'd517, 10'd1023, 1'b0);
        chk("R6 wrap case exercised", r6_hits > 0, 1);
        chk("R9 saturation exercised", r9_hits > 0, 1);

        // R1: mid-run reset must clear the buffer and restart phase and pointer
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out after mid-run reset", out, 0);
        rst_n = 1'b1;
        model_reset();
        repeat (DEPTH + 4) @(negedge clk);
        for (int i = 0; i < 16; i++) strobe(VECS[i].smp, VECS[i].spd, VECS[i].gain, 1'b0);

        summary();
        $finish;
    end
endmodule